// File: doc/BRIEF.md
# Upward-Growing Stack Pointer Unit

The block keeps an 8-bit stack pointer for a stack that lives in a small internal data RAM and grows toward higher addresses. It turns single-byte push and pop strobes into RAM write and read cycles. It also turns call and return strobes into two-byte sequences that save and restore a 16-bit return address. A push moves the pointer up and then writes at the new location. A pop reads at the current location and then moves the pointer down. After reset the pointer holds 07h, so the first push writes to 08h.

Software may load the pointer directly at any time, and that load overrides every other request in the same cycle. The RAM sits outside the block. The unit drives the RAM address, write enable and write data from registers. It expects read data back a fixed number of cycles later and returns popped bytes and reassembled return addresses on their own valid strobes. Two or more stack requests in one cycle are flagged as an error and do nothing else.

Top module: `stack_ptr_unit`

## Requirements
- R1: A synchronous reset sets sp_o to 07h and drives ram_we_o, busy_o, err_o, pop_valid_o and ret_valid_o low.
- R2: A lone push sets sp_o to the old pointer plus one on the next cycle. In that same cycle ram_addr_o equals the new pointer, ram_we_o is high and ram_wdata_o carries push_data_i.
- R3: A lone pop presents the old pointer on ram_addr_o with ram_we_o low and sets sp_o to the old pointer minus one. pop_valid_o pulses for one cycle RAM_LAT+1 edges after the address appears, and pop_data_o then holds the byte the RAM returned.
- R4: The pointer wraps modulo 256: a push from FFh writes at 00h, and a pop from 00h leaves FFh.
- R5: When sp_wr_i is high, sp_o takes sp_wdata_i on the next cycle and no RAM write occurs. Any push, pop, call or return in the same cycle is dropped, and a pending second step of a call or return is cancelled.
- R6: When two or more of push_i, pop_i, call_i and ret_i are high without sp_wr_i, err_o is high for one cycle, the pointer is unchanged and no RAM write occurs.
- R7: A call writes ret_addr_i bits 7:0 at pointer+1 and then bits 15:8 at pointer+2 on the following cycle. busy_o is high during the first write, and the pointer ends two higher.
- R8: A return reads the high byte at the pointer and then the low byte at pointer-1, and the pointer ends two lower. ret_valid_o pulses one cycle after the low byte is captured, with ret_pc_o = {high, low}. pop_valid_o and ret_valid_o are never high together.
- R9: While busy_o is high, push_i, pop_i, call_i and ret_i are ignored, and busy_o falls after one cycle unless a pointer load cancels the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push one byte |
| pop_i | input | 1 | Pop one byte |
| push_data_i | input | DW | Byte to push |
| call_i | input | 1 | Save a return address (two pushes) |
| ret_i | input | 1 | Restore a return address (two pops) |
| ret_addr_i | input | 2*DW | Return address to save |
| sp_wr_i | input | 1 | Direct pointer load strobe |
| sp_wdata_i | input | AW | Value to load into the pointer |
| ram_rdata_i | input | DW | Read data from the stack RAM |
| ram_addr_o | output | AW | Stack RAM address |
| ram_we_o | output | 1 | Stack RAM write enable |
| ram_wdata_o | output | DW | Stack RAM write data |
| pop_data_o | output | DW | Popped byte |
| pop_valid_o | output | 1 | pop_data_o is valid this cycle |
| ret_pc_o | output | 2*DW | Restored return address |
| ret_valid_o | output | 1 | ret_pc_o is valid this cycle |
| sp_o | output | AW | Current stack pointer |
| busy_o | output | 1 | Second step of a call or return pending |
| err_o | output | 1 | Conflicting stack requests seen last cycle |

## Verification
The assertions treat the strobes as synchronous, level-sampled requests. They count a request as a lone push, pop, call or return only when sp_wr_i is low and busy_o is low, since in any other cycle the request is dropped on purpose. The bench drives every strobe on the falling edge, holds it for exactly one cycle and returns to idle between scenarios. The only deliberate overlaps are the conflict, load-priority and busy-window cases. The bench models a RAM with a one-cycle synchronous read, so its read data lines up with the default RAM_LAT.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_LOAD, OP_PUSH, OP_POP, OP_CALL, OP_RET, OP_BAD
  } sp_op_e;

  typedef enum logic [1:0] {
    TAG_NONE, TAG_POP, TAG_RHI, TAG_RLO
  } rd_tag_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_CALL2, ST_RET2
  } seq_st_e;
endpackage

// File: rtl/sp_cmd_arb.sv
module sp_cmd_arb
  import sp_pkg::*;
(
  input  logic   push,
  input  logic   pop,
  input  logic   call,
  input  logic   ret,
  input  logic   load,
  input  logic   busy,
  output sp_op_e op
);
  logic [2:0] n_req;

  assign n_req = {2'b00, push} + {2'b00, pop} + {2'b00, call} + {2'b00, ret};

  // Pointer load wins outright; a pending second step blocks new requests.
  always_comb begin
    op = OP_NONE;
    if (load)             op = OP_LOAD;
    else if (busy)        op = OP_NONE;
    else if (n_req > 3'd1) op = OP_BAD;
    else if (push)        op = OP_PUSH;
    else if (pop)         op = OP_POP;
    else if (call)        op = OP_CALL;
    else if (ret)         op = OP_RET;
  end
endmodule

// File: rtl/sp_seq.sv
module sp_seq
  import sp_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] RST_VAL = 8'h07
) (
  input  logic            clk,
  input  logic            rst,
  input  sp_op_e          op,
  input  logic [DW-1:0]   push_data,
  input  logic [AW-1:0]   load_val,
  input  logic [2*DW-1:0] ret_addr,
  output logic [AW-1:0]   sp,
  output logic [AW-1:0]   ram_addr,
  output logic            ram_we,
  output logic [DW-1:0]   ram_wdata,
  output logic            busy,
  output logic            err,
  output rd_tag_e         tag
);
  seq_st_e       st;
  logic [DW-1:0] hi_hold;
  logic [AW-1:0] sp_up, sp_dn;

  assign sp_up = sp + AW'(1);
  assign sp_dn = sp - AW'(1);
  assign busy  = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp        <= RST_VAL;
      st        <= ST_IDLE;
      hi_hold   <= '0;
      ram_addr  <= '0;
      ram_we    <= 1'b0;
      ram_wdata <= '0;
      err       <= 1'b0;
      tag       <= TAG_NONE;
    end else begin
      ram_we <= 1'b0;
      err    <= 1'b0;
      tag    <= TAG_NONE;
      unique case (op)
        OP_LOAD: begin
          sp <= load_val;
          st <= ST_IDLE;
        end
        OP_PUSH: begin
          sp        <= sp_up;
          ram_addr  <= sp_up;
          ram_we    <= 1'b1;
          ram_wdata <= push_data;
        end
        OP_POP: begin
          ram_addr <= sp;
          sp       <= sp_dn;
          tag      <= TAG_POP;
        end
        OP_CALL: begin
          sp        <= sp_up;
          ram_addr  <= sp_up;
          ram_we    <= 1'b1;
          ram_wdata <= ret_addr[DW-1:0];
          hi_hold   <= ret_addr[2*DW-1:DW];
          st        <= ST_CALL2;
        end
        OP_RET: begin
          ram_addr <= sp;
          sp       <= sp_dn;
          tag      <= TAG_RHI;
          st       <= ST_RET2;
        end
        OP_BAD: err <= 1'b1;
        default: begin
          if (st == ST_CALL2) begin
            sp        <= sp_up;
            ram_addr  <= sp_up;
            ram_we    <= 1'b1;
            ram_wdata <= hi_hold;
          end else if (st == ST_RET2) begin
            ram_addr <= sp;
            sp       <= sp_dn;
            tag      <= TAG_RLO;
          end
          st <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/sp_rd_pipe.sv
module sp_rd_pipe
  import sp_pkg::*;
#(
  parameter int DW      = 8,
  parameter int RAM_LAT = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  rd_tag_e         tag_in,
  input  logic [DW-1:0]   rdata,
  output logic [DW-1:0]   pop_data,
  output logic            pop_valid,
  output logic [2*DW-1:0] ret_pc,
  output logic            ret_valid
);
  rd_tag_e       tag_st [1:RAM_LAT];
  logic [DW-1:0] hi_q;
  rd_tag_e       cap;

  // Delay each read tag until its data arrives from the RAM.
  for (genvar k = 1; k <= RAM_LAT; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)         tag_st[k] <= TAG_NONE;
      else if (k == 1) tag_st[k] <= tag_in;
      else             tag_st[k] <= tag_st[(k > 1) ? k-1 : 1];
    end
  end

  assign cap = tag_st[RAM_LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_data  <= '0;
      pop_valid <= 1'b0;
      ret_pc    <= '0;
      ret_valid <= 1'b0;
      hi_q      <= '0;
    end else begin
      pop_valid <= (cap == TAG_POP);
      ret_valid <= (cap == TAG_RLO);
      if (cap == TAG_POP) pop_data <= rdata;
      if (cap == TAG_RHI) hi_q     <= rdata;
      if (cap == TAG_RLO) ret_pc   <= {hi_q, rdata};
    end
  end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import sp_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int RAM_LAT = 1,
  parameter logic [AW-1:0] RST_VAL = 8'h07
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [DW-1:0]   push_data_i,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic [2*DW-1:0] ret_addr_i,
  input  logic            sp_wr_i,
  input  logic [AW-1:0]   sp_wdata_i,
  input  logic [DW-1:0]   ram_rdata_i,
  output logic [AW-1:0]   ram_addr_o,
  output logic            ram_we_o,
  output logic [DW-1:0]   ram_wdata_o,
  output logic [DW-1:0]   pop_data_o,
  output logic            pop_valid_o,
  output logic [2*DW-1:0] ret_pc_o,
  output logic            ret_valid_o,
  output logic [AW-1:0]   sp_o,
  output logic            busy_o,
  output logic            err_o
);
  sp_op_e  op;
  rd_tag_e tag;

  sp_cmd_arb u_arb (
    .push(push_i), .pop(pop_i), .call(call_i), .ret(ret_i),
    .load(sp_wr_i), .busy(busy_o), .op(op)
  );

  sp_seq #(.AW(AW), .DW(DW), .RST_VAL(RST_VAL)) u_seq (
    .clk(clk), .rst(rst), .op(op), .push_data(push_data_i),
    .load_val(sp_wdata_i), .ret_addr(ret_addr_i), .sp(sp_o),
    .ram_addr(ram_addr_o), .ram_we(ram_we_o), .ram_wdata(ram_wdata_o),
    .busy(busy_o), .err(err_o), .tag(tag)
  );

  sp_rd_pipe #(.DW(DW), .RAM_LAT(RAM_LAT)) u_rd (
    .clk(clk), .rst(rst), .tag_in(tag), .rdata(ram_rdata_i),
    .pop_data(pop_data_o), .pop_valid(pop_valid_o),
    .ret_pc(ret_pc_o), .ret_valid(ret_valid_o)
  );
endmodule

// File: rtl/stack_ptr_unit_chk.sv
module stack_ptr_unit_chk #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] RST_VAL = 8'h07
) (
  input logic            clk,
  input logic            rst,
  input logic            push_i,
  input logic            pop_i,
  input logic [DW-1:0]   push_data_i,
  input logic            call_i,
  input logic            ret_i,
  input logic [2*DW-1:0] ret_addr_i,
  input logic            sp_wr_i,
  input logic [AW-1:0]   sp_wdata_i,
  input logic [AW-1:0]   ram_addr_o,
  input logic            ram_we_o,
  input logic [DW-1:0]   ram_wdata_o,
  input logic            pop_valid_o,
  input logic            ret_valid_o,
  input logic [AW-1:0]   sp_o,
  input logic            busy_o,
  input logic            err_o
);
  logic go;
  assign go = !sp_wr_i && !busy_o;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (sp_o == RST_VAL && !ram_we_o && !busy_o && !err_o && !pop_valid_o && !ret_valid_o));

  a_r2_push_then_write: assert property (@(posedge clk) disable iff (rst)
    (go && push_i && !pop_i && !call_i && !ret_i) |=>
      (sp_o == $past(sp_o) + AW'(1) && ram_we_o && ram_addr_o == sp_o &&
       ram_wdata_o == $past(push_data_i)));

  a_r3_read_then_dec: assert property (@(posedge clk) disable iff (rst)
    (go && pop_i && !push_i && !call_i && !ret_i) |=>
      (sp_o == $past(sp_o) - AW'(1) && !ram_we_o && ram_addr_o == $past(sp_o)));

  a_r5_load_wins: assert property (@(posedge clk) disable iff (rst)
    sp_wr_i |=> (sp_o == $past(sp_wdata_i) && !ram_we_o && !busy_o));

  a_r6_conflict_flag: assert property (@(posedge clk) disable iff (rst)
    (go && $countones({push_i, pop_i, call_i, ret_i}) > 1) |=>
      (err_o && sp_o == $past(sp_o) && !ram_we_o));

  a_r7_call_low_first: assert property (@(posedge clk) disable iff (rst)
    (go && call_i && !push_i && !pop_i && !ret_i) |=>
      (busy_o && ram_we_o && ram_wdata_o == $past(ret_addr_i[DW-1:0])));

  a_r8_ret_reads: assert property (@(posedge clk) disable iff (rst)
    (go && ret_i && !push_i && !pop_i && !call_i) |=>
      (busy_o && !ram_we_o && ram_addr_o == $past(sp_o)));

  a_r8_valid_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pop_valid_o, ret_valid_o}));

  a_r9_busy_one_cycle: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> !busy_o);
endmodule

bind stack_ptr_unit stack_ptr_unit_chk #(.AW(AW), .DW(DW), .RST_VAL(RST_VAL)) u_chk (
  .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i), .push_data_i(push_data_i),
  .call_i(call_i), .ret_i(ret_i), .ret_addr_i(ret_addr_i), .sp_wr_i(sp_wr_i),
  .sp_wdata_i(sp_wdata_i), .ram_addr_o(ram_addr_o), .ram_we_o(ram_we_o),
  .ram_wdata_o(ram_wdata_o), .pop_valid_o(pop_valid_o), .ret_valid_o(ret_valid_o),
  .sp_o(sp_o), .busy_o(busy_o), .err_o(err_o)
);

// File: tb/sim_stack_ptr_unit.sv
module sim_stack_ptr_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_i = 0, pop_i = 0, call_i = 0, ret_i = 0, sp_wr_i = 0;
  logic [7:0]  push_data_i = '0, sp_wdata_i = '0;
  logic [15:0] ret_addr_i = '0;
  logic [7:0]  ram_rdata_i;
  logic [7:0]  ram_addr_o, ram_wdata_o, pop_data_o, sp_o;
  logic        ram_we_o, pop_valid_o, ret_valid_o, busy_o, err_o;
  logic [15:0] ret_pc_o;
  logic [7:0]  mem [0:255];
  int          tests = 0, fails = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Stack RAM model: one-cycle synchronous read.
  always @(posedge clk) begin
    if (ram_we_o) mem[ram_addr_o] <= ram_wdata_o;
    ram_rdata_i <= mem[ram_addr_o];
  end

  stack_ptr_unit u0 (
    .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i), .push_data_i(push_data_i),
    .call_i(call_i), .ret_i(ret_i), .ret_addr_i(ret_addr_i), .sp_wr_i(sp_wr_i),
    .sp_wdata_i(sp_wdata_i), .ram_rdata_i(ram_rdata_i), .ram_addr_o(ram_addr_o),
    .ram_we_o(ram_we_o), .ram_wdata_o(ram_wdata_o), .pop_data_o(pop_data_o),
    .pop_valid_o(pop_valid_o), .ret_pc_o(ret_pc_o), .ret_valid_o(ret_valid_o),
    .sp_o(sp_o), .busy_o(busy_o), .err_o(err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    push_i = 0; pop_i = 0; call_i = 0; ret_i = 0; sp_wr_i = 0;
  endtask

  // Drive one cycle of requests; returns just after the edge that took them.
  task automatic issue(input logic p, input logic po, input logic c, input logic r,
                       input logic w, input logic [7:0] pd, input logic [7:0] wd,
                       input logic [15:0] ra);
    @(negedge clk);
    push_i = p; pop_i = po; call_i = c; ret_i = r; sp_wr_i = w;
    push_data_i = pd; sp_wdata_i = wd; ret_addr_i = ra;
    @(negedge clk);
    clear_in();
  endtask

  task automatic t_reset();
    chk("R1 sp", sp_o, 8'h07);
    chk("R1 we", ram_we_o, 0);
    chk("R1 busy/err", {busy_o, err_o}, 0);
    chk("R1 valids", {pop_valid_o, ret_valid_o}, 0);
  endtask

  task automatic t_push_pop();
    issue(1, 0, 0, 0, 0, 8'hA5, 0, 0);
    chk("R2 sp", sp_o, 8'h08);
    chk("R2 addr/we/data", {ram_addr_o, ram_we_o, ram_wdata_o}, {8'h08, 1'b1, 8'hA5});
    issue(1, 0, 0, 0, 0, 8'h3C, 0, 0);
    chk("R2 second push", {sp_o, ram_addr_o, ram_wdata_o}, {8'h09, 8'h09, 8'h3C});
    issue(0, 1, 0, 0, 0, 0, 0, 0);
    chk("R3 addr/we", {ram_addr_o, ram_we_o}, {8'h09, 1'b0});
    chk("R3 sp", sp_o, 8'h08);
    @(negedge clk);
    chk("R3 not yet valid", pop_valid_o, 0);
    @(negedge clk);
    chk("R3 data", {pop_valid_o, pop_data_o}, {1'b1, 8'h3C});
    issue(0, 1, 0, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    chk("R3 lifo data", {pop_valid_o, pop_data_o, sp_o}, {1'b1, 8'hA5, 8'h07});
  endtask

  task automatic t_wrap();
    issue(0, 0, 0, 0, 1, 0, 8'hFF, 0);
    chk("R5 load", {sp_o, ram_we_o}, {8'hFF, 1'b0});
    issue(1, 0, 0, 0, 0, 8'h11, 0, 0);
    chk("R4 push wrap", {sp_o, ram_addr_o, ram_we_o}, {8'h00, 8'h00, 1'b1});
    issue(0, 1, 0, 0, 0, 0, 0, 0);
    chk("R4 pop wrap", {sp_o, ram_addr_o}, {8'hFF, 8'h00});
    repeat (2) @(negedge clk);
    chk("R4 wrap data", {pop_valid_o, pop_data_o}, {1'b1, 8'h11});
  endtask

  task automatic t_load_prio();
    issue(1, 0, 0, 0, 1, 8'h77, 8'h40, 0);
    chk("R5 load over push", {sp_o, ram_we_o}, {8'h40, 1'b0});
    issue(1, 1, 0, 0, 1, 8'h77, 8'h50, 0);
    chk("R5 load over conflict", {sp_o, ram_we_o, err_o}, {8'h50, 1'b0, 1'b0});
  endtask

  task automatic t_conflict();
    issue(0, 0, 0, 0, 1, 0, 8'h20, 0);
    issue(1, 1, 0, 0, 0, 8'h99, 0, 0);
    chk("R6 err", err_o, 1);
    chk("R6 sp/we", {sp_o, ram_we_o}, {8'h20, 1'b0});
    @(negedge clk);
    chk("R6 err one cycle", err_o, 0);
    issue(1, 0, 1, 0, 0, 8'h99, 0, 16'h1234);
    chk("R6 call+push", {err_o, sp_o, ram_we_o, busy_o}, {1'b1, 8'h20, 1'b0, 1'b0});
  endtask

  task automatic t_call_ret();
    issue(0, 0, 0, 0, 1, 0, 8'h30, 0);
    issue(0, 0, 1, 0, 0, 0, 0, 16'hBEEF);
    chk("R7 first write", {busy_o, ram_we_o, ram_addr_o, ram_wdata_o}, {1'b1, 1'b1, 8'h31, 8'hEF});
    push_i = 1; push_data_i = 8'h99;   // lands while busy_o is high
    @(negedge clk);
    clear_in();
    chk("R7 second write", {busy_o, ram_we_o, ram_addr_o, ram_wdata_o}, {1'b0, 1'b1, 8'h32, 8'hBE});
    chk("R7 sp+2", sp_o, 8'h32);
    @(negedge clk);
    chk("R9 push ignored", {ram_we_o, sp_o}, {1'b0, 8'h32});
    issue(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R8 high read", {busy_o, ram_we_o, ram_addr_o, sp_o}, {1'b1, 1'b0, 8'h32, 8'h31});
    @(negedge clk);
    chk("R8 low read", {busy_o, ram_addr_o, sp_o}, {1'b0, 8'h31, 8'h30});
    @(negedge clk);
    chk("R8 not yet valid", ret_valid_o, 0);
    @(negedge clk);
    chk("R8 ret pc", {ret_valid_o, ret_pc_o}, {1'b1, 16'hBEEF});
    chk("R8 no pop strobe", pop_valid_o, 0);
  endtask

  task automatic t_cancel();
    issue(0, 0, 0, 0, 1, 0, 8'h60, 0);
    issue(0, 0, 1, 0, 0, 0, 0, 16'h1234);
    sp_wr_i = 1; sp_wdata_i = 8'h70;
    @(negedge clk);
    clear_in();
    chk("R5 cancel", {sp_o, ram_we_o, busy_o}, {8'h70, 1'b0, 1'b0});
    @(negedge clk);
    chk("R5 stays cancelled", {sp_o, ram_we_o}, {8'h70, 1'b0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_push_pop();
    t_wrap();
    t_load_prio();
    t_conflict();
    t_call_ret();
    t_cancel();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule